// File: doc/BRIEF.md
# Slotted Flash-to-Configuration-Port Image Loader

This block copies a device configuration image out of a parallel NOR flash and into a byte-wide configuration port. The flash holds eight equal image slots. Slot 0 carries the system image and slot 1 a single user image. Slots 2 to 7 form a bank of extra images, chosen by a small selector input. Three pushbuttons start a load: one for the system image, one for the user image, and one for the selected extra image. The loader owns the flash and the buttons while the target device is unconfigured, because the device cannot manage them itself at that point.

A load runs in a fixed order. The program line is held low for a set number of cycles. The loader then waits for the initialisation line to go high. After that it reads consecutive flash bytes and presents one byte per configuration clock, until the done line rises or the slot is used up. When the last byte of the slot has gone out, a short window of extra configuration clocks lets the device finish. On success the loader pulses a reset to the freshly configured logic for a set number of cycles. If the initialisation line drops, or done never arrives, the loader stops, raises an error flag, and issues no reset.

Top module: `cfg_loader`

## Requirements
- R1: After reset: program line high, configuration clock low, flash read strobe high (inactive), application reset low, error flag low, busy low.
- R2: A pushbutton is acted on only after its synchronised level has stayed high for DEBOUNCE consecutive cycles. A shorter pulse starts nothing.
- R3: Each slot is 2^SLOT_LOG2 bytes, and slot n starts at flash address n·2^SLOT_LOG2. The system button loads slot 0, the user button loads slot 1, and the alternate button loads slot 2+sel.
- R4: A selector value of 6 or 7 loads slot 7. The selector is sampled only in the cycle the load starts.
- R5: A load first drives the program line low for exactly PROG_LOW cycles, with the configuration clock low and the flash strobe inactive. Streaming starts only once the initialisation line is high.
- R6: Each rising edge of the configuration clock delivers the byte stored at the next consecutive flash address, starting at the slot base. Data is held stable while the clock is high.
- R7: When done rises during streaming, no further byte is sent. The number of clock edges equals the byte count at which done rose.
- R8: After the last byte of a slot, the loader gives exactly GRACE_CLKS further clock rising edges. Done rising inside this window counts as success; otherwise the error flag is raised.
- R9: The initialisation line going low during streaming or the grace window aborts the load with the error flag set.
- R10: After success the application reset is high for exactly RST_HOLD cycles. A failed load gives no reset pulse. The error flag clears when a new load starts.
- R11: Button presses made while a load or reset pulse is in progress are ignored.
- R12: If several buttons are accepted in the same cycle, system beats user, and user beats alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_sys_i | input | 1 | Pushbutton: load system slot |
| btn_user_i | input | 1 | Pushbutton: load user slot |
| btn_alt_i | input | 1 | Pushbutton: load selected extra slot |
| slot_sel_i | input | $clog2(NUM_EXTRA) | Extra-slot selector |
| flash_addr_o | output | SLOT_LOG2+$clog2(NUM_EXTRA+2) | Flash byte address |
| flash_oe_n_o | output | 1 | Flash read strobe, active low |
| flash_data_i | input | 8 | Flash read data |
| cfg_prog_n_o | output | 1 | Configuration program line, active low |
| cfg_cclk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 8 | Configuration data byte |
| cfg_init_i | input | 1 | Configuration initialisation status |
| cfg_done_i | input | 1 | Configuration done status |
| app_rst_o | output | 1 | Reset pulse to configured logic |
| busy_o | output | 1 | Load or reset pulse in progress |
| err_o | output | 1 | Last load failed |

## Verification
The bench builds the loader with SLOT_LOG2=5, so each slot holds 32 bytes and the whole flash holds 256. At that size a full slot, the slot-end boundary and the grace window can all be exhausted in a few hundred cycles. DEBOUNCE=6 is long enough that a two-cycle glitch is a real rejection case. PROG_LOW=8, GRACE_CLKS=16 and RST_HOLD=16 keep their default meaning, so the pulse widths and the count of extra clocks are checked at their working values. Every slot base, including the clamped selector values, falls inside the small flash model, whose contents are a function of the address.

// File: rtl/cl_pkg.sv
package cl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_LOAD,
    ST_GRACE,
    ST_HOLD,
    ST_ERR
  } ld_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_LATCH,
    PH_EDGE
  } byte_phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cl_debounce.sv
module cl_debounce #(
  parameter int N_BTN    = 3,
  parameter int DEBOUNCE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_BTN-1:0] btn_i,
  output logic [N_BTN-1:0] press_o
);
  localparam int CNT_W = (DEBOUNCE < 2) ? 1 : $clog2(DEBOUNCE);

  for (genvar g = 0; g < N_BTN; g++) begin : g_btn
    logic             s1_q, s2_q, level_q, pulse_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q    <= 1'b0;
        s2_q    <= 1'b0;
        level_q <= 1'b0;
        pulse_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        s1_q    <= btn_i[g];
        s2_q    <= s1_q;
        pulse_q <= 1'b0;
        if (s2_q != level_q) begin
          if (cnt_q == CNT_W'(DEBOUNCE - 1)) begin
            level_q <= s2_q;
            pulse_q <= s2_q;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end

    assign press_o[g] = pulse_q;
  end

endmodule

// File: rtl/cl_slot_map.sv
module cl_slot_map #(
  parameter int SLOT_LOG2 = 18,
  parameter int NUM_EXTRA = 6,
  localparam int SLOT_W   = $clog2(NUM_EXTRA + 2),
  localparam int SEL_W    = $clog2(NUM_EXTRA),
  localparam int ADDR_W   = SLOT_LOG2 + SLOT_W
) (
  input  logic [2:0]        press_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] base_o
);
  logic [SLOT_W-1:0] slot;
  logic [SEL_W-1:0]  sel_clamped;

  always_comb begin
    if (int'(sel_i) > NUM_EXTRA - 1) sel_clamped = SEL_W'(NUM_EXTRA - 1);
    else                             sel_clamped = sel_i;

    if (press_i[0])      slot = '0;
    else if (press_i[1]) slot = SLOT_W'(1);
    else                 slot = SLOT_W'(2) + SLOT_W'(sel_clamped);

    start_o = |press_i;
    base_o  = {slot, {SLOT_LOG2{1'b0}}};
  end

endmodule

// File: rtl/cl_stream.sv
module cl_stream
  import cl_pkg::*;
#(
  parameter int SLOT_LOG2  = 18,
  parameter int ADDR_W     = 21,
  parameter int PROG_LOW   = 8,
  parameter int GRACE_CLKS = 16,
  parameter int RST_HOLD   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              flash_oe_n_o,
  input  logic [7:0]        flash_data_i,
  output logic              cfg_prog_n_o,
  output logic              cfg_cclk_o,
  output logic [7:0]        cfg_data_o,
  input  logic              cfg_init_i,
  input  logic              cfg_done_i,
  output logic              app_rst_o,
  output logic              busy_o,
  output logic              err_o
);
  localparam int TMR_MAX = max3(PROG_LOW, 2 * GRACE_CLKS, RST_HOLD);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  ld_state_e            state_q;
  byte_phase_e          phase_q;
  logic [SLOT_LOG2-1:0] cnt_q;
  logic [TMR_W-1:0]     tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      phase_q      <= PH_ADDR;
      cnt_q        <= '0;
      tmr_q        <= '0;
      flash_addr_o <= '0;
      flash_oe_n_o <= 1'b1;
      cfg_prog_n_o <= 1'b1;
      cfg_cclk_o   <= 1'b0;
      cfg_data_o   <= '0;
      app_rst_o    <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_ERR: begin
          if (start_i) begin
            state_q      <= ST_PROG;
            flash_addr_o <= base_i;
            cnt_q        <= '0;
            tmr_q        <= '0;
            cfg_prog_n_o <= 1'b0;
            err_o        <= 1'b0;
          end
        end
        ST_PROG: begin
          if (tmr_q == TMR_W'(PROG_LOW - 1)) begin
            cfg_prog_n_o <= 1'b1;
            tmr_q        <= '0;
            state_q      <= ST_WAIT_INIT;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_WAIT_INIT: begin
          if (cfg_init_i) begin
            state_q      <= ST_LOAD;
            phase_q      <= PH_ADDR;
            flash_oe_n_o <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (!cfg_init_i) begin
            state_q      <= ST_ERR;
            err_o        <= 1'b1;
            flash_oe_n_o <= 1'b1;
            cfg_cclk_o   <= 1'b0;
          end else if (cfg_done_i) begin
            state_q      <= ST_HOLD;
            app_rst_o    <= 1'b1;
            tmr_q        <= '0;
            flash_oe_n_o <= 1'b1;
            cfg_cclk_o   <= 1'b0;
          end else begin
            unique case (phase_q)
              PH_ADDR: begin
                cfg_cclk_o <= 1'b0;
                phase_q    <= PH_LATCH;
              end
              PH_LATCH: begin
                cfg_data_o <= flash_data_i;
                phase_q    <= PH_EDGE;
              end
              default: begin
                cfg_cclk_o <= 1'b1;
                phase_q    <= PH_ADDR;
                if (cnt_q == '1) begin
                  state_q      <= ST_GRACE;
                  tmr_q        <= '0;
                  flash_oe_n_o <= 1'b1;
                end else begin
                  cnt_q        <= cnt_q + 1'b1;
                  flash_addr_o <= flash_addr_o + 1'b1;
                end
              end
            endcase
          end
        end
        ST_GRACE: begin
          if (!cfg_init_i) begin
            state_q    <= ST_ERR;
            err_o      <= 1'b1;
            cfg_cclk_o <= 1'b0;
          end else if (cfg_done_i) begin
            state_q    <= ST_HOLD;
            app_rst_o  <= 1'b1;
            tmr_q      <= '0;
            cfg_cclk_o <= 1'b0;
          end else if (tmr_q == TMR_W'(2 * GRACE_CLKS)) begin
            state_q    <= ST_ERR;
            err_o      <= 1'b1;
            cfg_cclk_o <= 1'b0;
          end else begin
            cfg_cclk_o <= ~cfg_cclk_o;
            tmr_q      <= tmr_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (tmr_q == TMR_W'(RST_HOLD - 1)) begin
            app_rst_o <= 1'b0;
            state_q   <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_ERR);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int SLOT_LOG2  = 18,
  parameter int NUM_EXTRA  = 6,
  parameter int DEBOUNCE   = 65536,
  parameter int PROG_LOW   = 8,
  parameter int GRACE_CLKS = 16,
  parameter int RST_HOLD   = 16
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      btn_sys_i,
  input  logic                                      btn_user_i,
  input  logic                                      btn_alt_i,
  input  logic [$clog2(NUM_EXTRA)-1:0]              slot_sel_i,
  output logic [SLOT_LOG2+$clog2(NUM_EXTRA+2)-1:0]  flash_addr_o,
  output logic                                      flash_oe_n_o,
  input  logic [7:0]                                flash_data_i,
  output logic                                      cfg_prog_n_o,
  output logic                                      cfg_cclk_o,
  output logic [7:0]                                cfg_data_o,
  input  logic                                      cfg_init_i,
  input  logic                                      cfg_done_i,
  output logic                                      app_rst_o,
  output logic                                      busy_o,
  output logic                                      err_o
);
  localparam int ADDR_W = SLOT_LOG2 + $clog2(NUM_EXTRA + 2);

  logic [2:0]        press;
  logic              start;
  logic [ADDR_W-1:0] base;

  cl_debounce #(
    .N_BTN   (3),
    .DEBOUNCE(DEBOUNCE)
  ) i_debounce (
    .clk    (clk),
    .rst    (rst),
    .btn_i  ({btn_alt_i, btn_user_i, btn_sys_i}),
    .press_o(press)
  );

  cl_slot_map #(
    .SLOT_LOG2(SLOT_LOG2),
    .NUM_EXTRA(NUM_EXTRA)
  ) i_slot_map (
    .press_i(press),
    .sel_i  (slot_sel_i),
    .start_o(start),
    .base_o (base)
  );

  cl_stream #(
    .SLOT_LOG2 (SLOT_LOG2),
    .ADDR_W    (ADDR_W),
    .PROG_LOW  (PROG_LOW),
    .GRACE_CLKS(GRACE_CLKS),
    .RST_HOLD  (RST_HOLD)
  ) i_stream (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .base_i      (base),
    .flash_addr_o(flash_addr_o),
    .flash_oe_n_o(flash_oe_n_o),
    .flash_data_i(flash_data_i),
    .cfg_prog_n_o(cfg_prog_n_o),
    .cfg_cclk_o  (cfg_cclk_o),
    .cfg_data_o  (cfg_data_o),
    .cfg_init_i  (cfg_init_i),
    .cfg_done_i  (cfg_done_i),
    .app_rst_o   (app_rst_o),
    .busy_o      (busy_o),
    .err_o       (err_o)
  );

endmodule

// File: rtl/cl_checker.sv
module cl_checker #(
  parameter int ADDR_W   = 21,
  parameter int PROG_LOW = 8,
  parameter int RST_HOLD = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_n,
  input logic              cclk,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        data,
  input logic              done,
  input logic              app_rst,
  input logic              err
);
  localparam int PW = $clog2(PROG_LOW + 2);
  localparam int RW = $clog2(RST_HOLD + 2);

  logic [PW-1:0] prog_run_q;
  logic [RW-1:0] rst_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_run_q <= '0;
      rst_run_q  <= '0;
    end else begin
      prog_run_q <= prog_n  ? '0 : prog_run_q + 1'b1;
      rst_run_q  <= app_rst ? rst_run_q + 1'b1 : '0;
    end
  end

  // R5: program pulse width and quiet outputs meanwhile
  assert_prog_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_n) |-> prog_run_q == PW'(PROG_LOW));
  assert_prog_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !prog_n |-> (!cclk && oe_n));

  // R6: consecutive addresses and stable data under a high clock
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && $past(!oe_n) && addr != $past(addr)) |-> addr == $past(addr) + 1'b1);
  assert_data_stable_R6: assert property (@(posedge clk) disable iff (rst)
    cclk |-> $stable(data));

  // R10: reset pulse follows done, lasts RST_HOLD cycles, never with error
  assert_rst_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(app_rst) |-> $past(done));
  assert_rst_width_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(app_rst) |-> rst_run_q == RW'(RST_HOLD));
  assert_no_rst_on_err_R10: assert property (@(posedge clk) disable iff (rst)
    !(err && app_rst));

endmodule

bind cfg_loader cl_checker #(
  .ADDR_W  (ADDR_W),
  .PROG_LOW(PROG_LOW),
  .RST_HOLD(RST_HOLD)
) i_cl_checker (
  .clk    (clk),
  .rst    (rst),
  .prog_n (cfg_prog_n_o),
  .cclk   (cfg_cclk_o),
  .oe_n   (flash_oe_n_o),
  .addr   (flash_addr_o),
  .data   (cfg_data_o),
  .done   (cfg_done_i),
  .app_rst(app_rst_o),
  .err    (err_o)
);

// File: tb/test_cfg_loader.sv
`timescale 1ns/1ps
module test_cfg_loader;
  localparam int SLOT_LOG2 = 5;
  localparam int SLOT_B    = 1 << SLOT_LOG2;
  localparam int AW        = SLOT_LOG2 + 3;
  localparam int DEB       = 6;
  localparam int PROG_LOW  = 8;
  localparam int GRACE     = 16;
  localparam int RST_HOLD  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          btn_sys = 1'b0, btn_user = 1'b0, btn_alt = 1'b0;
  logic [2:0]    sel = '0;
  logic [AW-1:0] faddr;
  logic          foe_n, prog_n, cclk, app_rst, busy, err;
  logic [7:0]    fdata, cdata;
  logic          init_r = 1'b1, done_r = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] fdat(input logic [AW-1:0] a);
    return (8'(a) * 8'd7) ^ 8'h5A ^ {5'd0, a[AW-1:AW-3]};
  endfunction
  assign fdata = fdat(faddr);

  cfg_loader #(
    .SLOT_LOG2(SLOT_LOG2), .NUM_EXTRA(6), .DEBOUNCE(DEB),
    .PROG_LOW(PROG_LOW), .GRACE_CLKS(GRACE), .RST_HOLD(RST_HOLD)
  ) i_cfg_loader (
    .clk(clk), .rst(rst), .btn_sys_i(btn_sys), .btn_user_i(btn_user),
    .btn_alt_i(btn_alt), .slot_sel_i(sel), .flash_addr_o(faddr),
    .flash_oe_n_o(foe_n), .flash_data_i(fdata), .cfg_prog_n_o(prog_n),
    .cfg_cclk_o(cclk), .cfg_data_o(cdata), .cfg_init_i(init_r),
    .cfg_done_i(done_r), .app_rst_o(app_rst), .busy_o(busy), .err_o(err)
  );

  int n_checks = 0, n_fail = 0;
  int cycles = 0;
  // configuration port model state
  int exp_base = 0, done_after = 0, drop_at = 0;
  int k = 0, rises = 0, data_err = 0, prog_falls = 0;
  int prog_run = 0, prog_last = 0, init_dly = 0;
  int rst_run = 0, rst_last = 0, rst_pulses = 0;
  logic prev_cclk = 1'b0, prev_prog = 1'b1;

  always @(negedge clk) begin
    cycles = cycles + 1;
    if (!prog_n) begin
      if (prev_prog) prog_falls = prog_falls + 1;
      prog_run = prog_run + 1;
      init_r   = 1'b0;
      done_r   = 1'b0;
      k        = 0;
      init_dly = 0;
    end else begin
      if (!prev_prog) begin
        prog_last = prog_run;
        prog_run  = 0;
      end
      if (!init_r && init_dly < 3 && !(drop_at != 0 && k >= drop_at)) begin
        init_dly = init_dly + 1;
        if (init_dly == 3) init_r = 1'b1;
      end
      if (cclk && !prev_cclk) begin
        rises = rises + 1;
        if (k < SLOT_B && cdata != fdat(AW'(exp_base + k))) data_err = data_err + 1;
        k = k + 1;
        if (done_after != 0 && k >= done_after) done_r = 1'b1;
      end
      if (drop_at != 0 && k >= drop_at) init_r = 1'b0;
    end
    if (app_rst) rst_run = rst_run + 1;
    else if (rst_run != 0) begin
      rst_last   = rst_run;
      rst_pulses = rst_pulses + 1;
      rst_run    = 0;
    end
    prev_cclk = cclk;
    prev_prog = prog_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(negedge clk) if (cycles == 150000) begin
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    summary_and_end();
  end

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check(t < 5000, "idle timeout", t, 0);
  endtask

  // press mask bit0=sys bit1=user bit2=alt
  task automatic press(input logic [2:0] m);
    @(negedge clk);
    {btn_alt, btn_user, btn_sys} = m;
    repeat (DEB + 8) @(negedge clk);
    {btn_alt, btn_user, btn_sys} = 3'b000;
    repeat (DEB + 4) @(negedge clk);
  endtask

  int r0, f0, e0, p0;
  task automatic run_load(input logic [2:0] m, input int base, input int dn, input int dr);
    exp_base = base; done_after = dn; drop_at = dr;
    r0 = rises; f0 = prog_falls; e0 = data_err; p0 = rst_pulses;
    press(m);
    wait_idle();
  endtask

  task automatic t_reset();
    check(prog_n === 1'b1 && cclk === 1'b0 && foe_n === 1'b1, "R1 port idle", {prog_n, cclk, foe_n}, 3'b101);
    check(app_rst === 1'b0 && err === 1'b0 && busy === 1'b0, "R1 status low", {app_rst, err, busy}, 0);
  endtask

  task automatic t_glitch();
    f0 = prog_falls;
    @(negedge clk); btn_sys = 1'b1;
    repeat (2) @(negedge clk); btn_sys = 1'b0;
    repeat (DEB + 10) @(negedge clk);
    check(prog_falls == f0 && !busy, "R2 short pulse ignored", prog_falls - f0, 0);
  endtask

  task automatic t_sys();
    run_load(3'b001, 0, 10, 0);
    check(prog_falls - f0 == 1, "R2 debounced press starts", prog_falls - f0, 1);
    check(prog_last == PROG_LOW, "R5 program low width", prog_last, PROG_LOW);
    check(data_err == e0, "R3 R6 system slot bytes", data_err - e0, 0);
    check(rises - r0 == 10, "R7 stops at done", rises - r0, 10);
    check(rst_pulses - p0 == 1 && rst_last == RST_HOLD, "R10 reset pulse width", rst_last, RST_HOLD);
    check(err == 1'b0, "R10 no error", err, 0);
  endtask

  task automatic t_user();
    run_load(3'b010, SLOT_B, 5, 0);
    check(data_err == e0 && rises - r0 == 5, "R3 user slot", data_err - e0, 0);
  endtask

  task automatic t_alt(input logic [2:0] s, input int slot, input string tag);
    sel = s;
    fork
      run_load(3'b100, slot * SLOT_B, 12, 0);
      begin
        wait (prog_n == 1'b0);
        sel = 3'd0;
      end
    join
    check(data_err == e0 && rises - r0 == 12, tag, data_err - e0, 0);
  endtask

  task automatic t_full();
    run_load(3'b001, 0, SLOT_B, 0);
    check(data_err == e0 && rises - r0 == SLOT_B, "R6 whole slot", rises - r0, SLOT_B);
    check(!err && rst_pulses - p0 == 1, "R7 done on last byte", err, 0);
  endtask

  task automatic t_grace_ok();
    run_load(3'b010, SLOT_B, SLOT_B + 10, 0);
    check(!err && rst_pulses - p0 == 1, "R8 done in grace", err, 0);
    check(rises - r0 == SLOT_B + 10, "R8 grace edges until done", rises - r0, SLOT_B + 10);
  endtask

  task automatic t_timeout();
    run_load(3'b001, 0, 0, 0);
    check(err == 1'b1, "R8 error after grace", err, 1);
    check(rises - r0 == SLOT_B + GRACE, "R8 grace edge count", rises - r0, SLOT_B + GRACE);
    check(rst_pulses == p0, "R10 no reset on timeout", rst_pulses - p0, 0);
  endtask

  task automatic t_init_drop();
    run_load(3'b100, 4 * SLOT_B, 0, 5);
    check(err == 1'b1 && !busy, "R9 init drop aborts", err, 1);
    check(rises - r0 <= 6, "R9 streaming halted", rises - r0, 6);
    check(rst_pulses == p0, "R10 no reset on abort", rst_pulses - p0, 0);
    sel = 3'd2;
    run_load(3'b010, SLOT_B, 3, 0);
    check(err == 1'b0 && rst_pulses - p0 == 1, "R10 error cleared by new load", err, 0);
  endtask

  task automatic t_ignore();
    exp_base = 0; done_after = 20; drop_at = 0;
    r0 = rises; f0 = prog_falls; e0 = data_err;
    press(3'b001);
    press(3'b010);
    wait_idle();
    check(prog_falls - f0 == 1, "R11 press while busy ignored", prog_falls - f0, 1);
    check(data_err == e0 && rises - r0 == 20, "R11 running load unchanged", rises - r0, 20);
  endtask

  task automatic t_priority();
    run_load(3'b111, 0, 4, 0);
    check(data_err == e0 && prog_falls - f0 == 1, "R12 system wins", data_err - e0, 0);
    run_load(3'b110, SLOT_B, 4, 0);
    check(data_err == e0, "R12 user beats alternate", data_err - e0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_glitch();
    t_sys();
    t_user();
    t_alt(3'd3, 5, "R3 alternate slot sel 3");
    t_alt(3'd0, 2, "R3 alternate slot sel 0");
    t_alt(3'd6, 7, "R4 sel 6 clamps, sampled at start");
    t_alt(3'd7, 7, "R4 sel 7 clamps");
    t_full();
    t_grace_ok();
    t_timeout();
    t_init_drop();
    t_ignore();
    t_priority();
    summary_and_end();
  end

endmodule